// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Set, Clear and Toggle

This block is a 32-pin general-purpose I/O port on a simple memory-mapped register bus. The bus has a write strobe, a read strobe, a word address, write data and read data. The port holds an output value latch and a per-pin direction register. Each pin has three signals: the latched output value, an output enable taken from the direction register, and an input level that passes through a synchroniser before software can read it.

Software can write the output latch as a whole word. It can also use three write-only alias addresses to set, clear or invert chosen bits. Because each alias changes only the bits written as 1, two agents can drive different pins of the same port without a read-modify-write sequence. Bit n of every register belongs to pin n.

The port is parameterised for pin count, bus width, address width and synchroniser depth. Read data is registered. It appears in the cycle after the read strobe and is zero in every cycle that follows no read.

Top module: `gpio_port`

## Requirements
- R1: After reset the output latch and the direction register are zero, so every pin is an input with a low output value, and read data is zero.
- R2: Word address 0 (byte offset 0x00) is the output latch. A write loads the write data into the latch, with bit n driving `pin_out[n]`, and a read returns the latch.
- R3: A write to word address 1 (offset 0x04) sets each latch bit whose write-data bit is 1 and leaves the other latch bits unchanged.
- R4: A write to word address 2 (offset 0x08) clears each latch bit whose write-data bit is 1 and leaves the other latch bits unchanged.
- R5: A write to word address 3 (offset 0x0C) inverts each latch bit whose write-data bit is 1 and leaves the other latch bits unchanged.
- R6: A read from word address 1, 2 or 3 returns zero.
- R7: Word address 4 (offset 0x10) returns the synchronised pin input levels. A write to it changes neither the latch nor the direction register.
- R8: An input level present at `pin_in` at clock edge k is first returned by a read strobed at edge k+2. A read strobed at edge k or k+1 still returns the earlier level.
- R9: Word address 5 (offset 0x14) is the direction register. It is read and written directly, and a bit of 1 drives the matching `pin_oe` bit high, making that pin an output.
- R10: A write to any word address from 6 upward changes no state, and a read from such an address returns zero.
- R11: Read data appears in the cycle after a read strobe, with a read and a write in the same cycle returning the value from before the write. In any cycle that follows no read strobe, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin input levels (asynchronous) |
| pin_out | output | 32 | Output latch value per pin |
| pin_oe | output | 32 | Output enable per pin (1 = output) |

## Verification
The assertions check several rules on every cycle. They cover the update rule of each write path to the latch (direct load, set, clear, toggle) and to the direction register. They also check that writes to the input view and to undefined addresses leave all state unchanged, that the aliases and undefined addresses read as zero, that read data returns to zero after an idle cycle, and that reads of the latch, the direction register and the input view return the value held before the edge. Only the bench's scenarios can show the exact two-edge latency from a pin change to a visible read, the reset state, and the combined effect of long random mixes of reads and writes against a behavioural reference model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Word-address map of the port; the offsets are fixed by software.
   typedef enum logic [2:0] {
      SEL_LATCH = 3'd0,
      SEL_SET   = 3'd1,
      SEL_CLR   = 3'd2,
      SEL_TGL   = 3'd3,
      SEL_PINS  = 3'd4,
      SEL_DIR   = 3'd5
   } gp_sel_e;

   localparam int unsigned GP_NUM_WORDS = 6;

   // One-hot write actions produced by the decoder.
   typedef struct packed {
      logic load;
      logic set;
      logic clr;
      logic tgl;
      logic dir;
   } gp_wr_t;

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
   import gpio_port_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   output gp_wr_t            wr,
   output logic              rd_hit,
   output gp_sel_e           rd_sel
);

   logic    in_map;
   gp_sel_e sel;

   assign in_map = (addr < ADDR_W'(GP_NUM_WORDS));
   assign sel    = gp_sel_e'(addr[2:0]);

   always_comb begin
      wr = '0;
      if (wr_en && in_map) begin
         unique case (sel)
            SEL_LATCH: wr.load = 1'b1;
            SEL_SET:   wr.set  = 1'b1;
            SEL_CLR:   wr.clr  = 1'b1;
            SEL_TGL:   wr.tgl  = 1'b1;
            SEL_DIR:   wr.dir  = 1'b1;
            default:   wr      = '0;
         endcase
      end
   end

   assign rd_hit = rd_en && in_map;
   assign rd_sel = sel;

endmodule

// File: rtl/gpio_port_latch.sv
module gpio_port_latch
   import gpio_port_pkg::*;
#(
   parameter int unsigned N_PINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  gp_wr_t            wr,
   input  logic [N_PINS-1:0] wbits,
   output logic [N_PINS-1:0] q
);

   logic [N_PINS-1:0] nxt;

   always_comb begin
      nxt = q;
      if (wr.load)     nxt = wbits;
      else if (wr.set) nxt = q | wbits;
      else if (wr.clr) nxt = q & ~wbits;
      else if (wr.tgl) nxt = q ^ wbits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int unsigned N_PINS = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] d,
   output logic [N_PINS-1:0] q
);

   logic [STAGES-1:0][N_PINS-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned N_PINS      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [N_PINS-1:0] pin_in,
   output logic [N_PINS-1:0] pin_out,
   output logic [N_PINS-1:0] pin_oe
);

   localparam int unsigned MIN_ADDR_W = $clog2(GP_NUM_WORDS);

   if (N_PINS < 1 || N_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_port: N_PINS must lie in 1..DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W || ADDR_W < 3) begin : g_bad_addr
      $error("gpio_port: ADDR_W too narrow for the register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must be at least 2");
   end

   gp_wr_t            wr;
   logic              rd_hit;
   gp_sel_e           rd_sel;
   logic [N_PINS-1:0] wbits;
   logic [N_PINS-1:0] out_q;
   logic [N_PINS-1:0] dir_q;
   logic [N_PINS-1:0] pin_sync;
   logic [DATA_W-1:0] rd_word;

   assign wbits = wdata[N_PINS-1:0];

   gpio_port_decode #(.ADDR_W(ADDR_W)) u_dec (
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .wr     (wr),
      .rd_hit (rd_hit),
      .rd_sel (rd_sel)
   );

   gpio_port_latch #(.N_PINS(N_PINS)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr),
      .wbits (wbits),
      .q     (out_q)
   );

   gpio_port_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (wr.dir) dir_q <= wbits;
   end

   always_comb begin
      rd_word = '0;
      if (rd_hit) begin
         case (rd_sel)
            SEL_LATCH: rd_word[N_PINS-1:0] = out_q;
            SEL_PINS:  rd_word[N_PINS-1:0] = pin_sync;
            SEL_DIR:   rd_word[N_PINS-1:0] = dir_q;
            default:   rd_word             = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rd_word;
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned N_PINS = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [N_PINS-1:0] pin_out,
   input logic [N_PINS-1:0] pin_oe,
   input logic [N_PINS-1:0] pin_sync
);

   localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_TGL   = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_PINS  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(5);
   localparam logic [ADDR_W-1:0] A_FIRST_FREE = ADDR_W'(6);

   logic [N_PINS-1:0] wb;
   assign wb = wdata[N_PINS-1:0];

   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == A_LATCH |=> pin_out == $past(wb));

   a_r2_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == A_LATCH |=> rdata[N_PINS-1:0] == $past(pin_out));

   a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == A_SET |=> pin_out == ($past(pin_out) | $past(wb)));

   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == A_CLR |=> pin_out == ($past(pin_out) & ~$past(wb)));

   a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == A_TGL |=> pin_out == ($past(pin_out) ^ $past(wb)));

   a_r6_alias_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && (addr == A_SET || addr == A_CLR || addr == A_TGL) |=> rdata == '0);

   a_r7_pins_ro: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == A_PINS |=> $stable(pin_out) && $stable(pin_oe));

   a_r8_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == A_PINS |=> rdata[N_PINS-1:0] == $past(pin_sync));

   a_r9_dir: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == A_DIR |=> pin_oe == $past(wb));

   a_r9_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == A_DIR |=> rdata[N_PINS-1:0] == $past(pin_oe));

   a_r10_free_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr >= A_FIRST_FREE |=> $stable(pin_out) && $stable(pin_oe));

   a_r10_free_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr >= A_FIRST_FREE |=> rdata == '0);

   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> rdata == '0);

endmodule

bind gpio_port gpio_port_chk #(
   .N_PINS (N_PINS),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .pin_sync (pin_sync)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_port dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .pin_in  (pin_in),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   // Behavioural reference model
   logic [31:0] m_out = '0;
   logic [31:0] m_dir = '0;
   logic [31:0] m_rd  = '0;
   logic [31:0] m_vis;
   logic [31:0] hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_out = '0; m_dir = '0; m_rd = '0;
         hist.delete();
      end else begin
         m_vis = (hist.size() >= 2) ? hist[1] : 32'h0;
         m_rd = 32'h0;
         if (rd_en) begin
            case (addr)
               4'd0: m_rd = m_out;
               4'd4: m_rd = m_vis;
               4'd5: m_rd = m_dir;
               default: m_rd = 32'h0;
            endcase
         end
         if (wr_en) begin
            case (addr)
               4'd0: m_out = wdata;
               4'd1: m_out = m_out | wdata;
               4'd2: m_out = m_out & ~wdata;
               4'd3: m_out = m_out ^ wdata;
               4'd5: m_dir = wdata;
               default: ;
            endcase
         end
         hist.push_front(pin_in);
         if (hist.size() > 3) void'(hist.pop_back());
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         chk("R2 pin_out vs model", pin_out, m_out);
         chk("R9 pin_oe vs model", pin_oe, m_dir);
         chk("R11 rdata vs model", rdata, m_rd);
      end
   end

   task automatic bus_write(logic [3:0] a, logic [31:0] d);
      @(negedge clk); #1;
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic bus_read(logic [3:0] a, logic [31:0] exp, string tag);
      @(negedge clk); #1;
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      chk(tag, rdata, exp);
      #1 rd_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 pin_out at reset", pin_out, 32'h0);
      chk("R1 pin_oe at reset", pin_oe, 32'h0);
      chk("R1 rdata at reset", rdata, 32'h0);
      #1 rst_n = 1'b1;
      bus_read(4'd5, 32'h0, "R1 direction after reset");
      bus_read(4'd0, 32'h0, "R1 latch after reset");

      // R2 .. R5: latch update rules
      bus_write(4'd0, 32'hA5A5_0F0F);
      chk("R2 pin_out after load", pin_out, 32'hA5A5_0F0F);
      bus_read(4'd0, 32'hA5A5_0F0F, "R2 latch readback");
      bus_write(4'd1, 32'h0000_F0F0);
      bus_read(4'd0, 32'hA5A5_FFFF, "R3 set alias");
      bus_write(4'd2, 32'hFFFF_0000);
      bus_read(4'd0, 32'h0000_FFFF, "R4 clear alias");
      bus_write(4'd3, 32'h0F0F_00FF);
      bus_read(4'd0, 32'h0F0F_FF00, "R5 toggle alias");
      bus_write(4'd3, 32'h0F0F_00FF);
      chk("R5 toggle twice restores", pin_out, 32'h0000_FFFF);

      // R6: aliases read zero
      bus_read(4'd1, 32'h0, "R6 set alias reads zero");
      bus_read(4'd2, 32'h0, "R6 clear alias reads zero");
      bus_read(4'd3, 32'h0, "R6 toggle alias reads zero");

      // R9: direction
      bus_write(4'd5, 32'h1234_5678);
      chk("R9 pin_oe follows direction", pin_oe, 32'h1234_5678);
      bus_read(4'd5, 32'h1234_5678, "R9 direction readback");

      // R8: two-edge synchroniser latency with back-to-back reads
      @(negedge clk); #1;
      pin_in = 32'h0;
      repeat (4) @(negedge clk);
      #1;
      pin_in = 32'hCAFE_F00D;
      rd_en = 1'b1; addr = 4'd4;
      @(negedge clk);
      chk("R8 read at edge k old level", rdata, 32'h0);
      @(negedge clk);
      chk("R8 read at edge k+1 old level", rdata, 32'h0);
      @(negedge clk);
      chk("R8 read at edge k+2 new level", rdata, 32'hCAFE_F00D);
      #1 rd_en = 1'b0;

      // R7: input view ignores writes
      bus_write(4'd4, 32'hFFFF_FFFF);
      chk("R7 latch unchanged by input-view write", pin_out, 32'h0000_FFFF);
      chk("R7 direction unchanged by input-view write", pin_oe, 32'h1234_5678);
      bus_read(4'd4, 32'hCAFE_F00D, "R7 input view still shows pins");

      // R10: undefined addresses
      bus_write(4'd6, 32'hFFFF_FFFF);
      bus_write(4'd9, 32'h0);
      bus_write(4'd15, 32'h5555_AAAA);
      chk("R10 latch unchanged", pin_out, 32'h0000_FFFF);
      chk("R10 direction unchanged", pin_oe, 32'h1234_5678);
      bus_read(4'd7, 32'h0, "R10 undefined read zero");
      bus_read(4'd15, 32'h0, "R10 top address read zero");

      // R11: idle zero, read and write in the same cycle return old value
      @(negedge clk);
      chk("R11 idle rdata zero", rdata, 32'h0);
      @(negedge clk); #1;
      rd_en = 1'b1; wr_en = 1'b1; addr = 4'd0; wdata = 32'h1111_2222;
      @(negedge clk);
      chk("R11 same-cycle read returns old latch", rdata, 32'h0000_FFFF);
      #1 rd_en = 1'b0; wr_en = 1'b0;

      // Random mix against the model
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk); #1;
         wr_en = $urandom_range(0, 1) == 1;
         rd_en = $urandom_range(0, 1) == 1;
         addr  = 4'($urandom_range(0, 15));
         wdata = $urandom;
         if ($urandom_range(0, 3) == 0) pin_in = $urandom;
      end
      @(negedge clk); #1;
      wr_en = 1'b0; rd_en = 1'b0;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule